// File: doc/BRIEF.md
# Color Lookup Table Host Access Port

This block is the processor-side access logic for a 256-entry, 24-bit color lookup table. The host sees three 8-bit color tables (red, green, blue) through four register codes on a 3-bit select bus with its top bit low. A single-cycle write or read strobe goes with each access, and an 8-bit data bus carries the byte. Each host data access moves one 8-bit color byte. The block gathers three bytes into one 24-bit word and makes a single internal table operation for that word. One shared address register points into the table and steps forward after every third data access.

To load colors, the host writes a start address with the write-mode code. It then writes red, green and blue bytes for each entry in turn. Every third byte writes the entry and moves the address on. To read colors, the host writes a start address with the read-mode code. The block fetches that entry at once. Data reads then return red, green and blue, and after the third byte the block fetches the next entry ahead of time.

The block also holds a pixel mask register, which is driven out to the display side. The table storage is a synchronous single-write, single-read array that can map onto block RAM. Host accesses must be separated by at least one idle clock cycle, so that a prefetched entry has reached the staging registers before the next data read.

Top module: `clut_host_port`

## Requirements
- R1: After reset, `rdata` is 0x00, `pix_mask` is 0xFF, and reading the table address returns 0x00.
- R2: With `sel[2]`=0 the codes are: 000 loads the address in write mode, 001 is color data, 010 is the pixel mask, and 011 loads the address in read mode. An access with `sel[2]`=1 changes nothing, and a read there returns 0x00.
- R3: Data bytes are taken in the order red, green, blue. Together they form one 24-bit entry with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Reading the entry back in read mode returns red, green, blue in that order.
- R4: In write mode, the third data write stores the 24 staged bits at the current address, and the address then increases by one.
- R5: Writing code 011 loads the address and fetches that entry. Each following data read returns the next color byte. After the third read the address increases by one and the new entry is fetched, so no wait is needed between entries.
- R6: When the address increases past 0xFF it wraps to 0x00, in both modes.
- R7: Reading code 000 or code 011 returns the same shared address. Writing either code overwrites that address and resets the byte position to red.
- R8: A data write in read mode loads the staging byte but does not write the table. A data read in write mode returns the staging byte and does not read the table. In both cases the byte position still advances, and the address still increases after every third access.
- R9: The pixel mask is written and read back unchanged through code 010, and is driven on `pix_mask`. It holds its value unless code 010 is written.
- R10: `rdata` is registered. It takes its new value at the clock edge that samples `rd_en`, and holds that value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Register select code |
| wr_en | input | 1 | Single-cycle write strobe; not asserted together with `rd_en` |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| pix_mask | output | 8 | Pixel mask value for the display side |

## Verification
Several behaviours are checked by assertions on every cycle. A table write always moves the address on by one, and the address wraps from 0xFF to 0x00. An address load resets the byte position to red. The table is never written in read mode. The mask and the read data hold their values when no access touches them. The bench scenarios cover what needs the whole table or a sequence of accesses: the red-green-blue packing of all 256 entries, the prefetch that keeps back-to-back entry reads correct, and the loss of the previous mode's address. They also show that cross-mode accesses and out-of-range select codes leave stored entries unchanged.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Register select codes on sel[1:0] when sel[2] is low
  localparam logic [1:0] SEL_WADDR = 2'b00;
  localparam logic [1:0] SEL_DATA  = 2'b01;
  localparam logic [1:0] SEL_MASK  = 2'b10;
  localparam logic [1:0] SEL_RADDR = 2'b11;

  // Byte position within one 24-bit entry
  localparam int          NUM_CH   = 3;
  localparam logic [1:0]  PH_RED   = 2'd0;
  localparam logic [1:0]  PH_BLUE  = 2'd2;

  typedef enum logic {
    MODE_WR = 1'b0,
    MODE_RD = 1'b1
  } acc_mode_t;
endpackage

// File: rtl/clut_palette_ram.sv
module clut_palette_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdat,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_waddr,
  input  logic                ld_raddr,
  input  logic                dat_wr,
  input  logic                dat_rd,
  input  logic [CH_W-1:0]     wdata,
  output logic [ADDR_W-1:0]   addr,
  output logic [CH_W-1:0]     cur_byte,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_waddr,
  output logic [3*CH_W-1:0]   ram_wdat,
  output logic                ram_re,
  output logic [ADDR_W-1:0]   ram_raddr,
  input  logic [3*CH_W-1:0]   ram_q
);
  localparam int ENTRY_W = NUM_CH * CH_W;

  acc_mode_t         mode;
  logic [1:0]        phase;
  logic [CH_W-1:0]   stage [NUM_CH];
  logic              fill_pend;
  logic              dat_acc;
  logic              last_byte;
  logic [1:0]        phase_nx;
  logic [ADDR_W-1:0] addr_inc;

  assign dat_acc   = dat_wr | dat_rd;
  assign last_byte = (phase == PH_BLUE);
  assign phase_nx  = last_byte ? PH_RED : phase + 2'd1;
  assign addr_inc  = addr + 1'b1;

  // Table requests
  assign ram_we    = dat_wr && (mode == MODE_WR) && last_byte;
  assign ram_waddr = addr;
  assign ram_wdat  = {stage[0], stage[1], wdata};
  assign ram_re    = ld_raddr || (dat_rd && (mode == MODE_RD) && last_byte);
  assign ram_raddr = ld_raddr ? wdata[ADDR_W-1:0] : addr_inc;

  assign cur_byte  = stage[phase];

  // Address, mode and byte position
  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      mode  <= MODE_WR;
      phase <= PH_RED;
    end else if (ld_waddr || ld_raddr) begin
      addr  <= wdata[ADDR_W-1:0];
      mode  <= ld_raddr ? MODE_RD : MODE_WR;
      phase <= PH_RED;
    end else if (dat_acc) begin
      phase <= phase_nx;
      if (last_byte) addr <= addr_inc;
    end
  end

  // Prefetch arrives one cycle after a table read request
  always_ff @(posedge clk) begin
    if (rst) fill_pend <= 1'b0;
    else     fill_pend <= ram_re;
  end

  // Staging registers, one per color channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[c] <= '0;
      end else begin
        if (fill_pend)
          stage[c] <= ram_q[ENTRY_W-1-c*CH_W -: CH_W];
        if (dat_wr && (phase == 2'(c)))
          stage[c] <= wdata;
      end
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R3

  AST_WRITE_BUMPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> addr == $past(addr) + 1'b1); // R4

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && !ld_waddr && !ld_raddr && last_byte && (addr == '1)) |=> addr == '0); // R6

  AST_LOAD_RESETS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (ld_waddr || ld_raddr) |=> (phase == PH_RED) && (addr == $past(wdata[ADDR_W-1:0]))); // R7

  AST_NO_WRITE_IN_RD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RD) |-> !ram_we); // R8
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [CH_W-1:0] wdata,
  output logic [CH_W-1:0] rdata,
  output logic [CH_W-1:0] pix_mask
);
  localparam int ENTRY_W = NUM_CH * CH_W;

  logic              std_sel;
  logic              ld_waddr, ld_raddr, dat_wr, dat_rd, mask_wr;
  logic [ADDR_W-1:0] addr;
  logic [CH_W-1:0]   cur_byte;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [ENTRY_W-1:0] ram_wdat, ram_q;

  assign std_sel  = ~sel[2];
  assign ld_waddr = wr_en & std_sel & (sel[1:0] == SEL_WADDR);
  assign ld_raddr = wr_en & std_sel & (sel[1:0] == SEL_RADDR);
  assign dat_wr   = wr_en & std_sel & (sel[1:0] == SEL_DATA);
  assign dat_rd   = rd_en & std_sel & (sel[1:0] == SEL_DATA);
  assign mask_wr  = wr_en & std_sel & (sel[1:0] == SEL_MASK);

  clut_seq #(.ADDR_W(ADDR_W), .CH_W(CH_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .ld_waddr (ld_waddr),
    .ld_raddr (ld_raddr),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd),
    .wdata    (wdata),
    .addr     (addr),
    .cur_byte (cur_byte),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .ram_wdat (ram_wdat),
    .ram_re   (ram_re),
    .ram_raddr(ram_raddr),
    .ram_q    (ram_q)
  );

  clut_palette_ram #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) ram_i (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdat (ram_wdat),
    .re   (ram_re),
    .raddr(ram_raddr),
    .q    (ram_q)
  );

  // Pixel mask register
  always_ff @(posedge clk) begin
    if (rst)          pix_mask <= '1;
    else if (mask_wr) pix_mask <= wdata;
  end

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!std_sel) begin
        rdata <= '0;
      end else begin
        case (sel[1:0])
          SEL_WADDR, SEL_RADDR: rdata <= CH_W'(addr);
          SEL_DATA:             rdata <= cur_byte;
          default:              rdata <= pix_mask;
        endcase
      end
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(pix_mask)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: tb/clut_host_port_tb.sv
module clut_host_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pix_mask;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];

  always #5 clk = ~clk;

  clut_host_port dut_i (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pix_mask(pix_mask)
  );

  function automatic logic [7:0] pat_r(int i); return 8'(i * 3 + 1); endfunction
  function automatic logic [7:0] pat_g(int i); return 8'(i) ^ 8'hA5; endfunction
  function automatic logic [7:0] pat_b(int i); return 8'(~i + 7); endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One strobe cycle followed by one idle cycle
  task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
    @(negedge clk);
  endtask

  task automatic put_entry(input int a, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    bus_wr(3'b001, r); bus_wr(3'b001, g); bus_wr(3'b001, b);
    m_r[a] = r; m_g[a] = g; m_b[a] = b;
  endtask

  task automatic get_entry(input int a, input string tag);
    logic [7:0] v;
    bus_rd(3'b001, v); check(v, m_r[a], {tag, " red"});
    bus_rd(3'b001, v); check(v, m_g[a], {tag, " green"});
    bus_rd(3'b001, v); check(v, m_b[a], {tag, " blue"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(rdata, 8'h00, "R1 rdata after reset");
    check(pix_mask, 8'hFF, "R1 mask after reset");
    bus_rd(3'b000, v); check(v, 8'h00, "R1 address after reset");

    // R9 mask write and readback
    bus_wr(3'b010, 8'h3C);
    check(pix_mask, 8'h3C, "R9 mask output");
    bus_rd(3'b010, v); check(v, 8'h3C, "R9 mask readback");

    // R2 codes with sel[2]=1 are ignored
    for (int s = 4; s < 8; s++) begin
      bus_wr(3'(s), 8'h99);
      bus_rd(3'(s), v); check(v, 8'h00, "R2 high select read");
    end
    check(pix_mask, 8'h3C, "R2 mask untouched");
    bus_rd(3'b011, v); check(v, 8'h00, "R2 address untouched");

    // R3 R4 fill whole table
    bus_wr(3'b000, 8'h00);
    for (int i = 0; i < 256; i++) begin
      put_entry(i, pat_r(i), pat_g(i), pat_b(i));
      if (i == 0) begin
        bus_rd(3'b000, v); check(v, 8'h01, "R4 address step after entry");
        bus_rd(3'b011, v); check(v, 8'h01, "R7 shared address via read code");
      end
    end
    bus_rd(3'b000, v); check(v, 8'h00, "R6 write-mode wrap");

    // R5 R3 read the whole table back to back
    bus_wr(3'b011, 8'h00);
    for (int i = 0; i < 256; i++) get_entry(i, "R5 R3 sweep");
    bus_rd(3'b011, v); check(v, 8'h00, "R6 read-mode wrap");

    // R10 rdata holds without reads, even across writes
    bus_rd(3'b010, v);
    bus_wr(3'b000, 8'h44);
    repeat (4) @(negedge clk);
    check(rdata, 8'h3C, "R10 rdata hold");

    // R7 address shared, last write wins
    bus_wr(3'b000, 8'h40);
    bus_wr(3'b011, 8'h80);
    bus_rd(3'b000, v); check(v, 8'h80, "R7 last address wins");
    // R7 phase reset on address load
    bus_wr(3'b011, 8'h10);
    bus_rd(3'b001, v); check(v, m_r[16], "R7 first byte");
    bus_wr(3'b011, 8'h20);
    bus_rd(3'b001, v); check(v, m_r[32], "R7 phase back to red");
    // R7 partial write dropped by reload
    bus_wr(3'b000, 8'h30);
    bus_wr(3'b001, 8'hEE);
    bus_wr(3'b011, 8'h30);
    get_entry(48, "R7 partial write not committed");

    // R8 data writes in read mode do not write the table
    bus_wr(3'b011, 8'h50);
    bus_wr(3'b001, 8'h11); bus_wr(3'b001, 8'h22); bus_wr(3'b001, 8'h33);
    bus_rd(3'b000, v); check(v, 8'h51, "R8 address steps in read mode writes");
    bus_wr(3'b011, 8'h50);
    get_entry(80, "R8 entry unchanged");

    // R8 data reads in write mode return staging
    bus_wr(3'b000, 8'h60);
    put_entry(96, 8'hAA, 8'hBB, 8'hCC);
    bus_rd(3'b001, v); check(v, 8'hAA, "R8 staged red");
    bus_rd(3'b001, v); check(v, 8'hBB, "R8 staged green");
    bus_rd(3'b001, v); check(v, 8'hCC, "R8 staged blue");
    bus_rd(3'b000, v); check(v, 8'h62, "R8 address steps in write mode reads");
    bus_wr(3'b011, 8'h60);
    get_entry(96, "R4 new entry stored");
    get_entry(97, "R8 next entry unchanged");

    // R6 R4 wrap at top entry in write mode
    bus_wr(3'b000, 8'hFF);
    put_entry(255, 8'h5A, 8'hC3, 8'h0F);
    bus_rd(3'b011, v); check(v, 8'h00, "R6 wrap after top write");
    bus_wr(3'b011, 8'hFF);
    get_entry(255, "R4 top entry");
    get_entry(0, "R6 prefetch across wrap");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule